// File: doc/BRIEF.md
# Read Delay Leveling Unit

This block gives every memory device on a channel the same total read latency. At the start of a leveling pass the controller supplies the minimum read-data offset that the system permits. For each device it then writes a pattern and reads it back, and it reports the read domain in which that device's data returned. The domain is the cycle offset observed on the channel.

After every device has reported, the unit takes the largest domain as the common target. It gives each device an extra programmed delay equal to the target minus that device's own domain. So propagation delay plus programmed delay is the same for every device.

The unit then issues one register-write request per device, carrying the device index and its delay. After those writes it issues one controller-configuration update holding the new read-data offset, and raises a done flag. A device whose delay does not fit the register field gets no write, and a sticky range-error flag is raised instead. Generating the command packets that carry these writes lies outside this unit.

Top module: `rd_delay_leveler`

## Requirements
- R1: While reset is held and after it is released, `wr_valid`, `cfg_valid`, `range_err` and `done` are all 0 until a pass produces them.
- R2: A pulse on `start` while the unit is idle or done latches `base_offset` and begins a collection phase. No register write is issued until every device index from 0 to NDEV-1 has reported a domain.
- R3: During collection, only the first report for a given device index is kept. A repeated report for the same index has no effect on that device's computed delay.
- R4: The target equals the largest reported domain. Each device's delay equals the target minus its own reported domain, as an unsigned value.
- R5: Writes go out in ascending device index, at most one per cycle, with `wr_dev` carrying the index and `wr_delay` the delay.
- R6: If a device's delay is greater than 2^DLY_W-1, that device gets no write and `range_err` becomes 1. `range_err` stays 1 until the next accepted `start`.
- R7: After the last device has been handled, `cfg_valid` pulses high for exactly one cycle. With it, `cfg_offset` equals the latched `base_offset` plus the target, modulo 2^OFS_W.
- R8: `done` rises in the cycle after the `cfg_valid` pulse. It stays 1 until an accepted `start`, and is 0 in the cycle after that start.
- R9: Measurement reports presented while no collection phase is active are ignored. They produce no write, no configuration pulse and no change of `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a leveling pass |
| base_offset | input | OFS_W | Minimum read-data offset permitted by the system |
| meas_valid | input | 1 | Measurement report strobe |
| meas_dev | input | DEV_W | Index of the reporting device |
| meas_domain | input | DOM_W | Read domain measured for that device |
| wr_valid | output | 1 | Delay-register write request |
| wr_dev | output | DEV_W | Device index of the write |
| wr_delay | output | DLY_W | Programmed delay value |
| cfg_valid | output | 1 | Controller configuration update pulse |
| cfg_offset | output | OFS_W | New controller read-data offset |
| range_err | output | 1 | A delay exceeded the field range during this pass |
| done | output | 1 | Pass complete |

## Verification
The assertions rely on three things about the inputs. `start` is not pulsed while a pass is still collecting or writing. Every device index in use is below NDEV. The sum of base offset and largest domain is expected to fit OFS_W bits. The bench drives `start` only once `done` is high or right after reset, and it draws device indices from a shuffled permutation of 0..NDEV-1. It also keeps the base offset low enough that the offset sum does not wrap. Random domains span the full DOM_W range, so both in-range and out-of-range delays occur. Directed passes pin the exact field limit, repeated reports and reports arriving outside a pass.

// File: rtl/rdl_pkg.sv
package rdl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEAS,
        ST_WRITE,
        ST_CFG,
        ST_DONE
    } rdl_state_e;

endpackage

// File: rtl/rdl_collect.sv
module rdl_collect #(
    parameter int NDEV  = 4,
    parameter int DOM_W = 4,
    parameter int DEV_W = $clog2(NDEV)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  enable,
    input  logic                  in_valid,
    input  logic [DEV_W-1:0]      in_dev,
    input  logic [DOM_W-1:0]      in_dom,
    output logic [NDEV*DOM_W-1:0] dom_tab,
    output logic                  all_seen,
    output logic [DOM_W-1:0]      max_dom
);

    typedef struct packed {
        logic [NDEV-1:0]            seen;
        logic [NDEV-1:0][DOM_W-1:0] tab;
        logic [DOM_W-1:0]           mx;
    } col_t;

    col_t col_d, col_q;
    logic accept;

    always_comb begin
        col_d  = col_q;
        accept = enable && in_valid && (32'(in_dev) < NDEV) && !col_q.seen[in_dev];
        if (clear) begin
            col_d.seen = '0;
            col_d.mx   = '0;
        end else if (accept) begin
            col_d.tab[in_dev]  = in_dom;
            col_d.seen[in_dev] = 1'b1;
            if (in_dom > col_q.mx) col_d.mx = in_dom;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else begin
            col_q <= col_d;
        end
    end

    assign dom_tab  = col_q.tab;
    assign all_seen = &col_q.seen;
    assign max_dom  = col_q.mx;

    // A device once reported stays reported, and its value stays, until clear
    AST_SEEN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((col_q.seen & $past(col_q.seen)) == $past(col_q.seen))); // R3

endmodule

// File: rtl/rdl_calc.sv
module rdl_calc #(
    parameter int DOM_W = 4,
    parameter int DLY_W = 3
) (
    input  logic [DOM_W-1:0] target,
    input  logic [DOM_W-1:0] dom,
    output logic [DLY_W-1:0] delay,
    output logic             fits
);

    logic [DOM_W-1:0] diff;
    assign diff = target - dom;

    generate
        if (DLY_W >= DOM_W) begin : g_wide
            assign delay = DLY_W'(diff);
            assign fits  = 1'b1;
        end else begin : g_narrow
            assign delay = diff[DLY_W-1:0];
            assign fits  = (diff >> DLY_W) == '0;
        end
    endgenerate

endmodule

// File: rtl/rd_delay_leveler.sv
module rd_delay_leveler
    import rdl_pkg::*;
#(
    parameter int NDEV  = 4,
    parameter int DOM_W = 4,
    parameter int DLY_W = 3,
    parameter int OFS_W = 6,
    localparam int DEV_W = $clog2(NDEV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OFS_W-1:0] base_offset,
    input  logic             meas_valid,
    input  logic [DEV_W-1:0] meas_dev,
    input  logic [DOM_W-1:0] meas_domain,
    output logic             wr_valid,
    output logic [DEV_W-1:0] wr_dev,
    output logic [DLY_W-1:0] wr_delay,
    output logic             cfg_valid,
    output logic [OFS_W-1:0] cfg_offset,
    output logic             range_err,
    output logic             done
);

    localparam logic [DEV_W-1:0] LAST_DEV = DEV_W'(NDEV - 1);

    typedef struct packed {
        rdl_state_e       st;
        logic [DEV_W-1:0] idx;
        logic [OFS_W-1:0] base;
        logic             wr_valid;
        logic [DEV_W-1:0] wr_dev;
        logic [DLY_W-1:0] wr_delay;
        logic             cfg_valid;
        logic [OFS_W-1:0] cfg_off;
        logic             err;
        logic             done;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                  col_clear;
    logic                  col_enable;
    logic [NDEV*DOM_W-1:0] dom_tab;
    logic                  all_seen;
    logic [DOM_W-1:0]      target;
    logic [DOM_W-1:0]      cur_dom;
    logic [DLY_W-1:0]      cur_delay;
    logic                  cur_fits;

    assign col_clear  = start && (ctl_q.st == ST_IDLE || ctl_q.st == ST_DONE);
    assign col_enable = (ctl_q.st == ST_MEAS);

    rdl_collect #(
        .NDEV (NDEV),
        .DOM_W(DOM_W),
        .DEV_W(DEV_W)
    ) i_collect (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (col_clear),
        .enable  (col_enable),
        .in_valid(meas_valid),
        .in_dev  (meas_dev),
        .in_dom  (meas_domain),
        .dom_tab (dom_tab),
        .all_seen(all_seen),
        .max_dom (target)
    );

    assign cur_dom = dom_tab[ctl_q.idx*DOM_W +: DOM_W];

    rdl_calc #(
        .DOM_W(DOM_W),
        .DLY_W(DLY_W)
    ) i_calc (
        .target(target),
        .dom   (cur_dom),
        .delay (cur_delay),
        .fits  (cur_fits)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.wr_valid  = 1'b0;
        ctl_d.cfg_valid = 1'b0;
        case (ctl_q.st)
            ST_IDLE, ST_DONE: begin
                if (ctl_q.st == ST_DONE) ctl_d.done = 1'b1;
                if (start) begin
                    ctl_d.st   = ST_MEAS;
                    ctl_d.base = base_offset;
                    ctl_d.err  = 1'b0;
                    ctl_d.done = 1'b0;
                end
            end
            ST_MEAS: begin
                if (all_seen) begin
                    ctl_d.st  = ST_WRITE;
                    ctl_d.idx = '0;
                end
            end
            ST_WRITE: begin
                ctl_d.wr_dev   = ctl_q.idx;
                ctl_d.wr_delay = cur_delay;
                if (cur_fits) ctl_d.wr_valid = 1'b1;
                else          ctl_d.err      = 1'b1;
                if (ctl_q.idx == LAST_DEV) ctl_d.st  = ST_CFG;
                else                       ctl_d.idx = ctl_q.idx + 1'b1;
            end
            ST_CFG: begin
                ctl_d.cfg_valid = 1'b1;
                ctl_d.cfg_off   = ctl_q.base + OFS_W'(target);
                ctl_d.st        = ST_DONE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wr_valid   = ctl_q.wr_valid;
    assign wr_dev     = ctl_q.wr_dev;
    assign wr_delay   = ctl_q.wr_delay;
    assign cfg_valid  = ctl_q.cfg_valid;
    assign cfg_offset = ctl_q.cfg_off;
    assign range_err  = ctl_q.err;
    assign done       = ctl_q.done;

    AST_WR_AFTER_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> all_seen); // R2
    AST_WR_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && $past(wr_valid)) |-> (wr_dev > $past(wr_dev))); // R5
    AST_TARGET_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WRITE) |-> (target >= cur_dom)); // R4
    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (range_err && !start) |=> range_err); // R6
    AST_CFG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> !cfg_valid); // R7
    AST_DONE_AFTER_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> done); // R8
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wr_valid && !cfg_valid)); // R9

endmodule

// File: tb/test_rd_delay_leveler.sv
module test_rd_delay_leveler;

    localparam int NDEV  = 4;
    localparam int DOM_W = 4;
    localparam int DLY_W = 3;
    localparam int OFS_W = 6;
    localparam int DEV_W = $clog2(NDEV);
    localparam int MAXD  = (1 << DLY_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [OFS_W-1:0] base_offset = '0;
    logic             meas_valid = 1'b0;
    logic [DEV_W-1:0] meas_dev = '0;
    logic [DOM_W-1:0] meas_domain = '0;
    logic             wr_valid;
    logic [DEV_W-1:0] wr_dev;
    logic [DLY_W-1:0] wr_delay;
    logic             cfg_valid;
    logic [OFS_W-1:0] cfg_offset;
    logic             range_err;
    logic             done;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    rd_delay_leveler #(
        .NDEV(NDEV), .DOM_W(DOM_W), .DLY_W(DLY_W), .OFS_W(OFS_W)
    ) i_rd_delay_leveler (
        .clk(clk), .rst_n(rst_n), .start(start), .base_offset(base_offset),
        .meas_valid(meas_valid), .meas_dev(meas_dev), .meas_domain(meas_domain),
        .wr_valid(wr_valid), .wr_dev(wr_dev), .wr_delay(wr_delay),
        .cfg_valid(cfg_valid), .cfg_offset(cfg_offset),
        .range_err(range_err), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int max_of(input int d[NDEV]);
        int m = 0;
        for (int i = 0; i < NDEV; i++) if (d[i] > m) m = d[i];
        return m;
    endfunction

    // Drive reports outside a pass and confirm nothing moves
    task automatic stray_reports(input int n);
        bit d0 = done;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            meas_valid  = 1'b1;
            meas_dev    = DEV_W'($urandom_range(NDEV - 1, 0));
            meas_domain = DOM_W'($urandom);
            chk(!wr_valid && !cfg_valid && done == d0, "R9 stray report", int'(wr_valid), 0);
        end
        @(negedge clk);
        meas_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(!wr_valid && !cfg_valid && done == d0, "R9 after stray", int'(done), int'(d0));
        end
    endtask

    task automatic run_pass(input int d[NDEV], input int base, input bit dup);
        int perm[NDEV];
        int tgt, exp_cnt, got_cnt, cyc, cfg_cyc, cfg_val, exp_err;
        int exp_dev[NDEV];
        int exp_dly[NDEV];
        bit seen_done;
        for (int i = 0; i < NDEV; i++) perm[i] = i;
        for (int i = NDEV - 1; i > 0; i--) begin
            int j = $urandom_range(i, 0);
            int t = perm[i];
            perm[i] = perm[j];
            perm[j] = t;
        end
        tgt = max_of(d);
        exp_cnt = 0;
        exp_err = 0;
        for (int i = 0; i < NDEV; i++) begin
            if (tgt - d[i] <= MAXD) begin
                exp_dev[exp_cnt] = i;
                exp_dly[exp_cnt] = tgt - d[i];
                exp_cnt++;
            end else exp_err = 1;
        end

        @(negedge clk);
        start = 1'b1;
        base_offset = OFS_W'(base);
        @(negedge clk);
        start = 1'b0;
        chk(!done && !range_err, "R8 done clears after start", int'(done), 0);

        for (int k = 0; k < NDEV; k++) begin
            int gap = $urandom_range(2, 0);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                meas_valid = 1'b0;
                chk(!wr_valid, "R2 no write before all reported", int'(wr_valid), 0);
            end
            @(negedge clk);
            meas_valid  = 1'b1;
            meas_dev    = DEV_W'(perm[k]);
            meas_domain = DOM_W'(d[perm[k]]);
            chk(!wr_valid, "R2 no write before all reported", int'(wr_valid), 0);
            if (dup && k == 1) begin
                @(negedge clk);
                meas_dev    = DEV_W'(perm[0]);
                meas_domain = DOM_W'(d[perm[0]] ^ 15);
                chk(!wr_valid, "R3 duplicate report", int'(wr_valid), 0);
            end
        end

        got_cnt = 0;
        cfg_cyc = -10;
        cfg_val = -1;
        seen_done = 1'b0;
        for (cyc = 0; cyc < 40 && !seen_done; cyc++) begin
            @(negedge clk);
            meas_valid = 1'b0;
            if (wr_valid) begin
                if (got_cnt < exp_cnt) begin
                    chk(int'(wr_dev) == exp_dev[got_cnt], "R5 write order", int'(wr_dev), exp_dev[got_cnt]);
                    chk(int'(wr_delay) == exp_dly[got_cnt], "R4 delay value", int'(wr_delay), exp_dly[got_cnt]);
                end
                got_cnt++;
            end
            if (cfg_valid) begin
                chk(cfg_cyc < 0, "R7 single cfg pulse", cyc, cfg_cyc);
                cfg_cyc = cyc;
                cfg_val = int'(cfg_offset);
                chk(!done, "R8 done after cfg", int'(done), 0);
            end
            if (done) begin
                seen_done = 1'b1;
                chk(cyc == cfg_cyc + 1, "R8 done one cycle after cfg", cyc, cfg_cyc + 1);
            end
        end
        chk(seen_done, "R8 pass completes", int'(seen_done), 1);
        chk(got_cnt == exp_cnt, "R6 number of writes", got_cnt, exp_cnt);
        chk(cfg_val == ((base + tgt) % (1 << OFS_W)), "R7 cfg offset", cfg_val, (base + tgt) % (1 << OFS_W));
        chk(int'(range_err) == exp_err, "R6 range error flag", int'(range_err), exp_err);
        repeat (2) begin
            @(negedge clk);
            chk(done && int'(range_err) == exp_err, "R6 R8 flags hold", int'(done), 1);
        end
    endtask

    initial begin
        #(20 * 200000);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        chk(!wr_valid && !cfg_valid && !range_err && !done, "R1 during reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!wr_valid && !cfg_valid && !range_err && !done, "R1 after reset", int'(range_err), 0);

        stray_reports(4);

        run_pass('{5, 5, 5, 5}, 3, 1'b0);
        run_pass('{0, 7, 3, 7}, 10, 1'b0);
        run_pass('{0, 8, 2, 8}, 1, 1'b0);
        run_pass('{15, 0, 9, 12}, 20, 1'b0);
        run_pass('{4, 6, 2, 5}, 0, 1'b1);
        stray_reports(5);
        run_pass('{1, 2, 3, 4}, 48, 1'b1);

        for (int p = 0; p < 40; p++) begin
            int d[NDEV];
            for (int i = 0; i < NDEV; i++) d[i] = $urandom_range(15, 0);
            run_pass(d, $urandom_range(48, 0), 1'($urandom_range(1, 0)));
            if (p % 10 == 0) stray_reports(2);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule